// File: doc/BRIEF.md
# Polyphase Coefficient Shift-Load Store

This block holds the programmable taps of a four-phase interpolating FIR filter. The storage is one byte-wide shift chain of 196 registers, grouped as four banks of 49 bytes, with one bank per filter phase. A host loads the taps one byte at a time over a valid/ready byte stream. Every accepted byte enters the head of the chain, and every stored byte moves one place along it. The host sends its 196-byte image from the highest index down to index 0. After the last byte, register i of the chain holds image byte i.

Each bank unpacks into 32 signed 11-bit taps and one 8-bit auxiliary byte. The taps are sign-extended to 16 bits and presented to the filter datapath on one flat bus. The storage is not double buffered. For that reason the block drives `filter_enable` low from the first byte of a download until the 196th byte has landed. A synchronous active-high reset reloads a built-in default image.

The default tap of phase p, slot k is 1000 − 15·|4k + p − 63|, which gives a symmetric lowpass-like taper. The default auxiliary byte is 0x02. The peak, slope and auxiliary value are parameters.

Top module: `poly_coef_store`

## Requirements
- R1: While `rst` is high at a clock edge, every register loads the default image. After that edge `filter_enable` is 1, every tap (phase p, slot k) equals 1000 − 15·|4k+p−63|, and every auxiliary byte is 0x02.
- R2: `cfg_ready` is the inverse of `rst`, so the block never back-pressures out of reset. A byte transfers on a rising edge where `cfg_valid` and `cfg_ready` are both 1. While `cfg_ready` is 0, `cfg_valid` has no effect.
- R3: Each transfer puts `cfg_data` into chain register 0 and moves register i to register i+1. Bank p holds chain registers 49p to 49p+48. After 196 transfers of image bytes 195 down to 0, chain register i holds image byte i.
- R4: Within bank p, group g (registers 3g, 3g+1, 3g+2 of the bank, g = 0..15) forms two taps. Tap slot 2g takes bits 7..0 from register 3g and bits 10..8 from bits 6..4 of register 3g+2. Tap slot 2g+1 takes bits 7..0 from register 3g+1 and bits 10..8 from bits 2..0 of register 3g+2. Bits 7 and 3 of register 3g+2 are ignored.
- R5: Each tap appears sign-extended from its bit 10 to 16 bits at `coef_o[(32p+k)*16 +: 16]`.
- R6: Register 48 of bank p appears unchanged at `aux_o[8p +: 8]`.
- R7: The first transfer of a download drives `filter_enable` to 0 at the same edge. It stays 0 while a download is incomplete.
- R8: `filter_enable` returns to 1 at the edge of the 196th transfer of a download. That is the same edge at which the last byte lands.
- R9: A `load_start` pulse with no transfer resets the byte count to zero and leaves `filter_enable` unchanged. A transfer in the same cycle as `load_start` counts as the first byte of a new download. Either way, 196 further transfers are needed before `filter_enable` rises.
- R10: A write presented while `rst` is high is ignored. After reset the default image is present and `filter_enable` is 1.
- R11: Without a transfer, all stored bytes and all outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; loads the default image |
| cfg_valid | input | 1 | Byte offered on `cfg_data` |
| cfg_ready | output | 1 | Byte accepted when high together with `cfg_valid` |
| cfg_data | input | 8 | Configuration byte |
| load_start | input | 1 | Pulse that restarts the download byte count |
| filter_enable | output | 1 | High when the stored taps form a complete image |
| coef_o | output | 2048 | 4 phases × 32 taps, each a 16-bit sign-extended tap |
| aux_o | output | 32 | One auxiliary byte per phase |

## Verification
The bench packs third-register bytes with the ignored bits 7 and 3 set and with bit 10 set on either tap. A design that swaps the nibble fields, leaks the pad bits or zero-extends would show a wrong tap. It downloads images whose per-bank auxiliary bytes differ, so a chain that runs the wrong way or puts the banks in the wrong order would place a wrong auxiliary byte. It probes `filter_enable` after one byte, after 195 bytes and after 196 bytes, and across a restart with and without a simultaneous write. An off-by-one count or a restart that drops the coincident byte would raise the enable one edge early or late. It also offers bytes during reset and checks that the defaults survive.

// File: rtl/coef_pkg.sv
package coef_pkg;

  localparam int BYTE_W = 8;
  localparam int COEF_W = 11;

  // Default tap for global tap index t = k*phases + p: a symmetric taper
  function automatic logic [COEF_W-1:0] dflt_tap(int p, int k, int phases,
                                                 int center, int peak, int slope);
    int t;
    int d;
    int v;
    t = k * phases + p;
    d = (t > center) ? (t - center) : (center - t);
    v = peak - slope * d;
    return COEF_W'(v);
  endfunction

  // Default content of chain register idx under the packing rule
  function automatic logic [BYTE_W-1:0] dflt_byte(int idx, int regs_per_bank,
                                                  int phases, int center, int peak,
                                                  int slope, int aux);
    int p;
    int r;
    int g;
    logic [COEF_W-1:0] ce;
    logic [COEF_W-1:0] co;
    p = idx / regs_per_bank;
    r = idx % regs_per_bank;
    if (r == regs_per_bank - 1) return BYTE_W'(aux);
    g  = r / 3;
    ce = dflt_tap(p, 2 * g, phases, center, peak, slope);
    co = dflt_tap(p, 2 * g + 1, phases, center, peak, slope);
    case (r % 3)
      0:       return ce[7:0];
      1:       return co[7:0];
      default: return {1'b0, ce[10:8], 1'b0, co[10:8]};
    endcase
  endfunction

endpackage

// File: rtl/coef_load_seq.sv
module coef_load_seq #(
  parameter int CHAIN_LEN = 196,
  localparam int CNT_W = $clog2(CHAIN_LEN)
) (
  input  logic clk,
  input  logic rst,
  input  logic wr,
  input  logic load_start,
  output logic filter_enable
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(CHAIN_LEN - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt           <= '0;
      filter_enable <= 1'b1;
    end else if (wr) begin
      if (load_start) begin
        cnt           <= CNT_W'(1);
        filter_enable <= 1'b0;
      end else if (cnt == LAST) begin
        cnt           <= '0;
        filter_enable <= 1'b1;
      end else begin
        cnt           <= cnt + 1'b1;
        filter_enable <= 1'b0;
      end
    end else if (load_start) begin
      cnt <= '0;
    end
  end

  // R7: a partial download never shows an enabled filter
  p_enable_low_mid_r7: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |-> !filter_enable);

  // R7: any byte that does not complete a download drops the enable
  p_first_write_r7: assert property (@(posedge clk) disable iff (rst)
    (wr && (load_start || cnt != LAST)) |=> !filter_enable);

  // R8: the final byte restores the enable
  p_enable_rise_r8: assert property (@(posedge clk) disable iff (rst)
    (wr && !load_start && cnt == LAST) |=> filter_enable);

  // R9: a bare restart clears the count and keeps the enable
  p_restart_r9: assert property (@(posedge clk) disable iff (rst)
    (load_start && !wr) |=> (cnt == '0) && $stable(filter_enable));

endmodule

// File: rtl/coef_shift_chain.sv
module coef_shift_chain
  import coef_pkg::*;
#(
  parameter int NUM_PHASES    = 4,
  parameter int REGS_PER_BANK = 49,
  parameter int DFLT_PEAK     = 1000,
  parameter int DFLT_SLOPE    = 15,
  parameter int DFLT_AUX      = 2,
  localparam int CHAIN_LEN    = NUM_PHASES * REGS_PER_BANK,
  localparam int TAPS         = 2 * ((REGS_PER_BANK - 1) / 3),
  localparam int CENTER       = (NUM_PHASES * TAPS) / 2 - 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          shift_en,
  input  logic [BYTE_W-1:0]             din,
  output logic [CHAIN_LEN*BYTE_W-1:0]   chain_o
);

  logic [BYTE_W-1:0] regs [CHAIN_LEN];

  for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_reg
    localparam logic [BYTE_W-1:0] DV =
      dflt_byte(i, REGS_PER_BANK, NUM_PHASES, CENTER, DFLT_PEAK, DFLT_SLOPE, DFLT_AUX);
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst)           regs[i] <= DV;
        else if (shift_en) regs[i] <= din;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst)           regs[i] <= DV;
        else if (shift_en) regs[i] <= regs[i-1];
      end
    end
    assign chain_o[i*BYTE_W +: BYTE_W] = regs[i];
  end

  // R3: the incoming byte lands at the head
  p_shift_head_r3: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> regs[0] == $past(din));

  // R3: the tail takes its neighbour's old value
  p_shift_tail_r3: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> regs[CHAIN_LEN-1] == $past(regs[CHAIN_LEN-2]));

  // R11: no transfer, no movement
  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(regs[0]) && $stable(regs[CHAIN_LEN-1]));

endmodule

// File: rtl/coef_unpack.sv
module coef_unpack
  import coef_pkg::*;
#(
  parameter int REGS_PER_BANK = 49,
  parameter int OUT_W         = 16,
  localparam int GROUPS       = (REGS_PER_BANK - 1) / 3,
  localparam int TAPS         = 2 * GROUPS
) (
  input  logic [REGS_PER_BANK*BYTE_W-1:0] bank_i,
  output logic [TAPS*OUT_W-1:0]           coef_o,
  output logic [BYTE_W-1:0]               aux_o
);

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    logic [BYTE_W-1:0] lo_even;
    logic [BYTE_W-1:0] lo_odd;
    logic [BYTE_W-1:0] hi;
    logic [COEF_W-1:0] c_even;
    logic [COEF_W-1:0] c_odd;
    logic [1:0]        pad_unused;

    assign lo_even    = bank_i[(3*g)*BYTE_W   +: BYTE_W];
    assign lo_odd     = bank_i[(3*g+1)*BYTE_W +: BYTE_W];
    assign hi         = bank_i[(3*g+2)*BYTE_W +: BYTE_W];
    assign pad_unused = {hi[7], hi[3]};
    assign c_even     = {hi[6:4], lo_even};
    assign c_odd      = {hi[2:0], lo_odd};

    assign coef_o[(2*g)*OUT_W   +: OUT_W] = {{(OUT_W-COEF_W){c_even[COEF_W-1]}}, c_even};
    assign coef_o[(2*g+1)*OUT_W +: OUT_W] = {{(OUT_W-COEF_W){c_odd[COEF_W-1]}}, c_odd};
  end

  if (REGS_PER_BANK > 3 * GROUPS + 1) begin : g_spare
    logic [(REGS_PER_BANK-3*GROUPS-1)*BYTE_W-1:0] spare_unused;
    assign spare_unused = bank_i[3*GROUPS*BYTE_W +: (REGS_PER_BANK-3*GROUPS-1)*BYTE_W];
  end

  assign aux_o = bank_i[(REGS_PER_BANK-1)*BYTE_W +: BYTE_W];

endmodule

// File: rtl/poly_coef_store.sv
module poly_coef_store
  import coef_pkg::*;
#(
  parameter int NUM_PHASES    = 4,
  parameter int REGS_PER_BANK = 49,
  parameter int OUT_W         = 16,
  parameter int DFLT_PEAK     = 1000,
  parameter int DFLT_SLOPE    = 15,
  parameter int DFLT_AUX      = 2,
  localparam int CHAIN_LEN    = NUM_PHASES * REGS_PER_BANK,
  localparam int TAPS         = 2 * ((REGS_PER_BANK - 1) / 3),
  localparam int BANK_BITS    = REGS_PER_BANK * BYTE_W
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              cfg_valid,
  output logic                              cfg_ready,
  input  logic [7:0]                        cfg_data,
  input  logic                              load_start,
  output logic                              filter_enable,
  output logic [NUM_PHASES*TAPS*OUT_W-1:0]  coef_o,
  output logic [NUM_PHASES*BYTE_W-1:0]      aux_o
);

  logic                        wr;
  logic [CHAIN_LEN*BYTE_W-1:0] chain;

  assign cfg_ready = !rst;
  assign wr        = cfg_valid && cfg_ready;

  coef_load_seq #(.CHAIN_LEN(CHAIN_LEN)) u_seq (
    .clk           (clk),
    .rst           (rst),
    .wr            (wr),
    .load_start    (load_start),
    .filter_enable (filter_enable)
  );

  coef_shift_chain #(
    .NUM_PHASES    (NUM_PHASES),
    .REGS_PER_BANK (REGS_PER_BANK),
    .DFLT_PEAK     (DFLT_PEAK),
    .DFLT_SLOPE    (DFLT_SLOPE),
    .DFLT_AUX      (DFLT_AUX)
  ) u_chain (
    .clk      (clk),
    .rst      (rst),
    .shift_en (wr),
    .din      (cfg_data),
    .chain_o  (chain)
  );

  for (genvar p = 0; p < NUM_PHASES; p++) begin : g_phase
    coef_unpack #(
      .REGS_PER_BANK (REGS_PER_BANK),
      .OUT_W         (OUT_W)
    ) u_unpack (
      .bank_i (chain[p*BANK_BITS +: BANK_BITS]),
      .coef_o (coef_o[p*TAPS*OUT_W +: TAPS*OUT_W]),
      .aux_o  (aux_o[p*BYTE_W +: BYTE_W])
    );
  end

  // R11: outputs hold between transfers
  p_out_stable_r11: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(coef_o) && $stable(aux_o));

  // R6: the auxiliary byte of the last bank moves with the chain
  p_aux_shift_r6: assert property (@(posedge clk) disable iff (rst)
    wr |=> aux_o[(NUM_PHASES-1)*BYTE_W +: BYTE_W] ==
           $past(chain[(CHAIN_LEN-2)*BYTE_W +: BYTE_W]));

endmodule

// File: tb/sim_poly_coef_store.sv
module sim_poly_coef_store;

  typedef struct packed {
    logic [7:0]  b0;
    logic [7:0]  b1;
    logic [7:0]  b2;
    logic [15:0] even;
    logic [15:0] odd;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{8'h00, 8'h00, 8'h00, 16'h0000, 16'h0000},
    '{8'hFF, 8'hFF, 8'h77, 16'hFFFF, 16'hFFFF},
    '{8'hFF, 8'h00, 8'h88, 16'h00FF, 16'h0000},
    '{8'h34, 8'h12, 8'h35, 16'h0334, 16'hFD12},
    '{8'h00, 8'h00, 8'h40, 16'hFC00, 16'h0000},
    '{8'hFF, 8'hFF, 8'h33, 16'h03FF, 16'h03FF},
    '{8'h01, 8'h80, 8'h04, 16'h0001, 16'hFC80},
    '{8'hAA, 8'h55, 8'hF2, 16'hFFAA, 16'h0255}
  };

  logic          clk = 1'b0;
  logic          rst;
  logic          cfg_valid;
  logic          cfg_ready;
  logic [7:0]    cfg_data;
  logic          load_start;
  logic          filter_enable;
  logic [2047:0] coef_o;
  logic [31:0]   aux_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  poly_coef_store u0 (
    .clk           (clk),
    .rst           (rst),
    .cfg_valid     (cfg_valid),
    .cfg_ready     (cfg_ready),
    .cfg_data      (cfg_data),
    .load_start    (load_start),
    .filter_enable (filter_enable),
    .coef_o        (coef_o),
    .aux_o         (aux_o)
  );

  function automatic logic [15:0] tap(int p, int k);
    return coef_o[(32*p+k)*16 +: 16];
  endfunction

  function automatic logic [15:0] dflt(int p, int k);
    int t;
    t = 4*k + p - 63;
    if (t < 0) t = -t;
    return 16'(1000 - 15*t);
  endfunction

  // image byte i; e < 0 is the plain pattern, else vector e overlaid
  function automatic logic [7:0] img(int e, int i);
    int base;
    base = 49*(e % 4) + 6*e;
    if (e >= 0 && i == base)     return VEC[e].b0;
    if (e >= 0 && i == base + 1) return VEC[e].b1;
    if (e >= 0 && i == base + 2) return VEC[e].b2;
    return 8'(i*7 + 3);
  endfunction

  function automatic logic [15:0] ref_tap(int e, int p, int k);
    logic [7:0]  lo;
    logic [7:0]  hi;
    logic [10:0] v;
    lo = img(e, 49*p + 3*(k/2) + (k%2));
    hi = img(e, 49*p + 3*(k/2) + 2);
    v  = (k%2 == 1) ? {hi[2:0], lo} : {hi[6:4], lo};
    return {{5{v[10]}}, v};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push(logic [7:0] d);
    cfg_valid = 1'b1;
    cfg_data  = d;
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  task automatic download(int e);
    for (int i = 195; i >= 0; i--) push(img(e, i));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual running expected finished");
    finish_run();
  end

  initial begin
    rst        = 1'b1;
    cfg_valid  = 1'b1;   // R10: offered during reset
    cfg_data   = 8'h5A;
    load_start = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2 ready low in reset", 32'(cfg_ready), 32'd0);
    chk("R1 enable after reset", 32'(filter_enable), 32'd1);
    rst       = 1'b0;
    cfg_valid = 1'b0;
    @(negedge clk);
    chk("R2 ready high", 32'(cfg_ready), 32'd1);
    chk("R1 default p0 k0", 32'(tap(0, 0)), 32'(dflt(0, 0)));
    chk("R1 default p3 k15", 32'(tap(3, 15)), 32'(dflt(3, 15)));
    chk("R1 default p2 k31", 32'(tap(2, 31)), 32'(dflt(2, 31)));
    chk("R1 default p1 k20", 32'(tap(1, 20)), 32'(dflt(1, 20)));
    chk("R1 default aux", 32'(aux_o), 32'h02020202);

    // R11: idle cycles change nothing
    repeat (5) @(negedge clk);
    chk("R11 hold tap", 32'(tap(3, 15)), 32'(dflt(3, 15)));
    chk("R11 hold aux", 32'(aux_o), 32'h02020202);

    // R7 / R8 / R3: plain download
    push(img(-1, 195));
    chk("R7 enable drops on first byte", 32'(filter_enable), 32'd0);
    for (int i = 194; i >= 1; i--) push(img(-1, i));
    chk("R7 enable low after 195 bytes", 32'(filter_enable), 32'd0);
    push(img(-1, 0));
    chk("R8 enable high after 196 bytes", 32'(filter_enable), 32'd1);
    for (int p = 0; p < 4; p++) begin
      chk("R3 R6 aux byte per bank", 32'(aux_o[8*p +: 8]), 32'(img(-1, 49*p + 48)));
      for (int k = 0; k < 32; k++)
        chk("R3 R4 R5 tap", 32'(tap(p, k)), 32'(ref_tap(-1, p, k)));
    end

    // R4 / R5: packing vectors
    for (int e = 0; e < NV; e++) begin
      download(e);
      chk("R4 R5 even tap", 32'(tap(e % 4, 4*e)), 32'(VEC[e].even));
      chk("R4 R5 odd tap", 32'(tap(e % 4, 4*e + 1)), 32'(VEC[e].odd));
      chk("R8 enable after vector load", 32'(filter_enable), 32'd1);
    end

    // R9: bare restart mid-download
    for (int i = 0; i < 100; i++) push(8'(i));
    load_start = 1'b1;
    @(negedge clk);
    load_start = 1'b0;
    chk("R9 restart keeps enable low", 32'(filter_enable), 32'd0);
    for (int i = 0; i < 195; i++) push(8'(i));
    chk("R9 195 after restart still low", 32'(filter_enable), 32'd0);
    push(8'h11);
    chk("R9 196 after restart high", 32'(filter_enable), 32'd1);

    // R9: restart coinciding with a byte
    for (int i = 0; i < 10; i++) push(8'(i));
    load_start = 1'b1;
    push(8'h22);
    load_start = 1'b0;
    for (int i = 0; i < 194; i++) push(8'(i));
    chk("R9 coincident restart 195 low", 32'(filter_enable), 32'd0);
    push(8'h33);
    chk("R9 coincident restart 196 high", 32'(filter_enable), 32'd1);

    // R10: reset mid-download with a byte offered
    for (int i = 0; i < 20; i++) push(8'hC3);
    rst       = 1'b1;
    cfg_valid = 1'b1;
    cfg_data  = 8'hEE;
    repeat (2) @(negedge clk);
    rst       = 1'b0;
    cfg_valid = 1'b0;
    @(negedge clk);
    chk("R10 enable after reset", 32'(filter_enable), 32'd1);
    chk("R10 default tap restored", 32'(tap(0, 0)), 32'(dflt(0, 0)));
    chk("R10 default aux restored", 32'(aux_o), 32'h02020202);

    finish_run();
  end

endmodule